// File: doc/BRIEF.md
# Tree-Based Pseudo-LRU Way Selector

This block picks replacement ways for an 8-way set-associative cache. It does not hold tags or data. For every set it keeps a small binary decision tree with one bit per internal node, which gives W-1 bits for W ways. Each node bit says which of its two subtrees holds the less recently used ways. The cache controller reports each access by giving the set and, on a hit, the way that hit. On a miss the block picks the victim itself and returns it as the way to fill.

An access rewrites only the nodes on the path from the root to the touched way. Each of those nodes is pointed away from the touched way. The new bits come from the way number alone, and the old node values are never read. A separate lookup port lets the controller see, for any set, the way that would be evicted next and the raw node bits. All outputs are registered, so results appear one cycle after the inputs are sampled.

Top module: `plru_tree_sel`

## Requirements
- R1: A synchronous active-high reset clears every node bit of every set. After reset, a lookup of any set gives look_tree = 0 and look_way = 0.
- R2: Node k of a set's tree is bit k of look_tree. Node 0 is the root, and the children of node i are nodes 2i+1 and 2i+2. An access to way w writes each node on its path with the complement of the way-number bit that chooses the branch at that level, most significant bit at the root. Node value 0 means the lower half is less recently used; 1 means the upper half is. From the reset state, a hit on way 6 gives look_tree = 7'h40.
- R3: An access leaves unchanged every node that is off the accessed path, and every other set.
- R4: look_way is found by starting at the root and taking the lower child on a 0 and the upper child on a 1. The leaf reached is the way number.
- R5: On a miss (acc_miss = 1), the victim is computed from the set's state before the access. That victim is then used as the accessed way for the tree update, and fill_way reports it one cycle later.
- R6: On a hit (acc_miss = 0), the tree is updated with acc_way, and fill_way equals acc_way one cycle later.
- R7: Right after any access to a set, the victim of that set is never the way just used.
- R8: look_way and look_tree show the state of look_set as it was just before the same clock edge. An update at that edge becomes visible one cycle later.
- R9: When acc_valid is 0, no node changes and fill_valid is 0 in the next cycle. fill_valid is 1 one cycle after each valid access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is reported this cycle |
| acc_miss | input | 1 | 1 = miss (the block picks the way), 0 = hit on acc_way |
| acc_set | input | 4 | Set index of the access |
| acc_way | input | 3 | Way that hit (ignored on a miss) |
| look_set | input | 4 | Set to inspect |
| look_way | output | 3 | Registered victim of look_set |
| look_tree | output | 7 | Registered node bits of look_set |
| fill_valid | output | 1 | Registered: previous cycle carried an access |
| fill_way | output | 3 | Registered way used by the previous access |

## Verification
The assertions assume that acc_set and look_set stay below the set count, and that acc_way is a legal way whenever a hit is reported. With default parameters every encoding is legal, and the stimulus draws all fields across their full ranges. The assertions also assume that no access counts during reset. The bench keeps acc_valid low while rst is high. Random traffic often points look_set at the set that was just accessed, so the check that the most recently used way is never the victim runs on many different trees.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Number of internal nodes in a binary tree over a power-of-two way count
  function automatic int tree_nodes(input int ways);
    return ways - 1;
  endfunction

  // Bits needed to hold a way number (at least one)
  function automatic int way_bits(input int ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction

endpackage

// File: rtl/plru_walk.sv
// Descends a node vector from the root and returns the leaf marked least recently used.
module plru_walk #(
  parameter int WAYS = 8
) (
  input  logic [plru_pkg::tree_nodes(WAYS)-1:0] tree,
  output logic [plru_pkg::way_bits(WAYS)-1:0]   way
);
  localparam int NODES = plru_pkg::tree_nodes(WAYS);
  localparam int WAY_W = plru_pkg::way_bits(WAYS);
  localparam int LEVELS = $clog2(WAYS);

  logic [WAYS-1:0]  tree_pad;
  logic [WAY_W-1:0] idx;
  logic             b;

  assign tree_pad = {{(WAYS-NODES){1'b0}}, tree};

  always_comb begin
    idx = '0;
    way = '0;
    b   = 1'b0;
    for (int l = 0; l < LEVELS; l++) begin
      b   = tree_pad[idx];
      way = (way << 1) | WAY_W'(b);
      idx = (idx << 1) + WAY_W'(1) + WAY_W'(b);
    end
  end
endmodule

// File: rtl/plru_path_mask.sv
// Turns a way number into the set of nodes on its path and the values they take.
module plru_path_mask #(
  parameter int WAYS = 8
) (
  input  logic [plru_pkg::way_bits(WAYS)-1:0]   way,
  output logic [plru_pkg::tree_nodes(WAYS)-1:0] mask,
  output logic [plru_pkg::tree_nodes(WAYS)-1:0] val
);
  localparam int NODES = plru_pkg::tree_nodes(WAYS);
  localparam int WAY_W = plru_pkg::way_bits(WAYS);
  localparam int LEVELS = $clog2(WAYS);

  logic [WAYS-1:0]  mask_pad;
  logic [WAYS-1:0]  val_pad;
  logic [WAY_W-1:0] idx;
  logic             b;

  always_comb begin
    mask_pad = '0;
    val_pad  = '0;
    idx      = '0;
    b        = 1'b0;
    for (int l = 0; l < LEVELS; l++) begin
      b             = way[LEVELS-1-l];
      mask_pad[idx] = 1'b1;
      val_pad[idx]  = ~b;   // point away from the touched half
      idx           = (idx << 1) + WAY_W'(1) + WAY_W'(b);
    end
  end

  assign mask = mask_pad[NODES-1:0];
  assign val  = val_pad[NODES-1:0];
endmodule

// File: rtl/plru_tree_store.sv
// Per-set node storage with per-bit write enables and two combinational read ports.
module plru_tree_store #(
  parameter int SETS  = 16,
  parameter int NODES = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [$clog2(SETS)-1:0] wr_set,
  input  logic [NODES-1:0]        wr_mask,
  input  logic [NODES-1:0]        wr_val,
  input  logic [$clog2(SETS)-1:0] rd_a_set,
  output logic [NODES-1:0]        rd_a,
  input  logic [$clog2(SETS)-1:0] rd_b_set,
  output logic [NODES-1:0]        rd_b
);
  logic [NODES-1:0] state_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) state_q[s] <= '0;
    end else if (wr_en) begin
      for (int n = 0; n < NODES; n++) begin
        if (wr_mask[n]) state_q[wr_set][n] <= wr_val[n];
      end
    end
  end

  assign rd_a = state_q[rd_a_set];
  assign rd_b = state_q[rd_b_set];

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_q[rd_b_set] == '0 && state_q[rd_a_set] == '0)); // R1

  AST_PATH_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((state_q[$past(wr_set)] ^ $past(wr_val)) & $past(wr_mask)) == '0); // R2

  AST_OFF_PATH_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((state_q[$past(wr_set)] ^ $past(state_q[wr_set])) & ~$past(wr_mask)) == '0); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> state_q[$past(rd_b_set)] == $past(state_q[rd_b_set])); // R9
endmodule

// File: rtl/plru_tree_sel.sv
// Top: pseudo-LRU victim selection and path update for a set-associative cache.
module plru_tree_sel #(
  parameter int WAYS = 8,
  parameter int SETS = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  acc_valid,
  input  logic                                  acc_miss,
  input  logic [$clog2(SETS)-1:0]               acc_set,
  input  logic [plru_pkg::way_bits(WAYS)-1:0]   acc_way,
  input  logic [$clog2(SETS)-1:0]               look_set,
  output logic [plru_pkg::way_bits(WAYS)-1:0]   look_way,
  output logic [plru_pkg::tree_nodes(WAYS)-1:0] look_tree,
  output logic                                  fill_valid,
  output logic [plru_pkg::way_bits(WAYS)-1:0]   fill_way
);
  localparam int NODES = plru_pkg::tree_nodes(WAYS);
  localparam int WAY_W = plru_pkg::way_bits(WAYS);
  localparam int SET_W = $clog2(SETS);

  logic [NODES-1:0] acc_tree, look_tree_c, wr_mask, wr_val, merged_tree;
  logic [WAY_W-1:0] acc_victim, look_victim, upd_way, chk_way;

  plru_tree_store #(.SETS(SETS), .NODES(NODES)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(acc_valid), .wr_set(acc_set), .wr_mask(wr_mask), .wr_val(wr_val),
    .rd_a_set(acc_set), .rd_a(acc_tree),
    .rd_b_set(look_set), .rd_b(look_tree_c)
  );

  plru_walk #(.WAYS(WAYS)) u_acc_walk  (.tree(acc_tree),    .way(acc_victim));
  plru_walk #(.WAYS(WAYS)) u_look_walk (.tree(look_tree_c), .way(look_victim));

  assign upd_way = acc_miss ? acc_victim : acc_way;

  plru_path_mask #(.WAYS(WAYS)) u_path (.way(upd_way), .mask(wr_mask), .val(wr_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      look_way   <= '0;
      look_tree  <= '0;
      fill_valid <= 1'b0;
      fill_way   <= '0;
    end else begin
      look_way   <= look_victim;
      look_tree  <= look_tree_c;
      fill_valid <= acc_valid;
      fill_way   <= upd_way;
    end
  end

  // Checking path: the tree as it will be after this access, walked independently
  assign merged_tree = (acc_tree & ~wr_mask) | (wr_val & wr_mask);
  plru_walk #(.WAYS(WAYS)) u_chk_walk (.tree(merged_tree), .way(chk_way));

  AST_MRU_NOT_VICTIM: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> chk_way != upd_way); // R7

  AST_HIT_FILL: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_miss) |=> (fill_valid && fill_way == $past(acc_way))); // R6

  AST_MISS_FILL: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_miss) |=> (fill_valid && fill_way == $past(acc_victim))); // R5

  AST_IDLE_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !fill_valid); // R9

  AST_LOOK_DELAY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> look_tree == $past(look_tree_c)); // R8
endmodule

// File: tb/test_plru_tree_sel.sv
`timescale 1ns/1ps
module test_plru_tree_sel;
  localparam int WAYS = 8;
  localparam int SETS = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       acc_valid, acc_miss;
  logic [3:0] acc_set, look_set;
  logic [2:0] acc_way;
  logic [2:0] look_way, fill_way;
  logic [6:0] look_tree;
  logic       fill_valid;

  int checks = 0;
  int fails  = 0;
  logic [6:0] ref_t [SETS];

  always #4 clk = ~clk;

  plru_tree_sel #(.WAYS(WAYS), .SETS(SETS)) i_plru_tree_sel (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_miss(acc_miss),
    .acc_set(acc_set), .acc_way(acc_way), .look_set(look_set),
    .look_way(look_way), .look_tree(look_tree),
    .fill_valid(fill_valid), .fill_way(fill_way)
  );

  // Model: narrow a way range by halves, heap-numbered nodes
  function automatic logic [6:0] m_update(input logic [6:0] t, input int w);
    int lo = 0, size = WAYS, idx = 0;
    while (size > 1) begin
      int half = size / 2;
      bit up = (w >= lo + half);
      t[idx] = !up;
      idx = 2 * idx + 1 + int'(up);
      if (up) lo += half;
      size = half;
    end
    return t;
  endfunction

  function automatic int m_victim(input logic [6:0] t);
    int lo = 0, size = WAYS, idx = 0;
    while (size > 1) begin
      int half = size / 2;
      bit up = t[idx];
      idx = 2 * idx + 1 + int'(up);
      if (up) lo += half;
      size = half;
    end
    return lo;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive, predict, compare after the edge
  task automatic step(input bit v, input bit m, input int s, input int w, input int ls);
    logic [6:0] e_tree;
    int e_lw, e_fw;
    @(negedge clk);
    acc_valid = v; acc_miss = m; acc_set = 4'(s); acc_way = 3'(w); look_set = 4'(ls);
    e_tree = ref_t[ls];
    e_lw   = m_victim(e_tree);
    e_fw   = 0;
    if (v) begin
      e_fw = m ? m_victim(ref_t[s]) : w;
      ref_t[s] = m_update(ref_t[s], e_fw);
    end
    @(posedge clk);
    #1;
    check(look_tree == e_tree, "R8 look_tree", int'(look_tree), int'(e_tree));
    check(int'(look_way) == e_lw, "R4 look_way", int'(look_way), e_lw);
    check(fill_valid == v, "R9 fill_valid", int'(fill_valid), int'(v));
    if (v) check(int'(fill_way) == e_fw, m ? "R5 miss fill_way" : "R6 hit fill_way",
                 int'(fill_way), e_fw);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int last_set, last_way;
    for (int s = 0; s < SETS; s++) ref_t[s] = '0;
    rst = 1'b1; acc_valid = 0; acc_miss = 0; acc_set = 0; acc_way = 0; look_set = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    step(0, 0, 0, 0, 5);
    check(look_tree == 7'h00 && look_way == 3'd0, "R1 reset tree/victim",
          int'(look_tree), 0);

    // R2: way-6 hit pattern from reset
    step(1, 0, 3, 6, 3);
    step(0, 0, 0, 0, 3);
    check(look_tree == 7'h40, "R2 way-6 path bits", int'(look_tree), 'h40);
    check(look_way == 3'd0, "R4 victim after way-6 hit", int'(look_way), 0);

    // R3: other sets untouched
    step(0, 0, 0, 0, 2);
    check(look_tree == 7'h00, "R3 neighbour set unchanged", int'(look_tree), 0);

    // R5: miss picks way 0 and updates as way 0
    step(1, 1, 3, 7, 3);
    check(fill_way == 3'd0, "R5 miss victim way", int'(fill_way), 0);
    step(0, 0, 0, 0, 3);
    check(look_tree == 7'h4B, "R3 off-path bit kept after miss", int'(look_tree), 'h4B);
    check(look_way == 3'd4, "R4 descent to way 4", int'(look_way), 4);

    // R9: idle cycles leave state alone
    step(0, 1, 3, 2, 3);
    step(0, 0, 0, 0, 3);
    check(look_tree == 7'h4B, "R9 idle keeps tree", int'(look_tree), 'h4B);

    // Random traffic with R7 checks on the set just touched
    last_set = -1; last_way = 0;
    for (int i = 0; i < 4000; i++) begin
      int s = int'($urandom_range(SETS - 1));
      int w = int'($urandom_range(WAYS - 1));
      bit v = ($urandom_range(7) != 0);
      bit m = $urandom_range(1) == 1;
      int ls = ($urandom_range(1) == 1 && last_set >= 0) ? last_set : int'($urandom_range(SETS - 1));
      step(v, m, s, w, ls);
      if (last_set >= 0 && ls == last_set)
        check(int'(look_way) != last_way, "R7 MRU not victim", int'(look_way), last_way);
      if (v) begin
        last_set = s;
        last_way = int'(fill_way);
      end else begin
        last_set = -1;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule